// File: doc/BRIEF.md
# Peripheral Interrupt Flag and Enable Unit

This unit collects interrupt events for a parallel-port and timer peripheral and raises a single active-low interrupt request to the CPU. There are seven event inputs: two control lines for each of the two ports, the serial shift register, and two timers. Each event is a single-cycle pulse from the neighbouring logic. The pulse sets a sticky flag, and each flag is masked by its own enable bit.

Software uses a byte-wide register port with read and write strobes. It reads the flags, clears them by writing ones, and changes individual enable bits through a command byte. In that byte, bit 7 chooses set or clear and the lower bits choose which enables are affected. No read-modify-write is needed. Bit 7 of the flag register is a summary bit: it is high when any enabled flag is pending.

Top module: `ifr_irq_unit`

## Requirements
- R1: After reset, all flags and all enables are 0, and `irq_n` is 1.
- R2: A 1 on bit i of `evt` in a clock cycle sets flag i at that clock edge. The source order is fixed on `evt` and in both registers:
  - bit 0: port A control line 2
  - bit 1: port A control line 1
  - bit 2: shift register
  - bit 3: port B control line 2
  - bit 4: port B control line 1
  - bit 5: timer 2
  - bit 6: timer 1
- R3: A write to the flag register (slot `FLAG_SLOT`, default 13) clears each flag whose data bit in 6..0 is 1. It leaves the other flags unchanged. Data bit 7 is ignored.
- R4: If an event pulse and a write-1-to-clear hit the same flag in the same cycle, the flag is 1 afterwards.
- R5: A write to the enable register (slot `FLAG_SLOT+1`) with data bit 7 = 1 sets each enable whose data bit in 6..0 is 1. The other enables keep their value.
- R6: A write to the enable register with data bit 7 = 0 clears each enable whose data bit in 6..0 is 1. The other enables keep their value.
- R7: A read of the enable register returns the seven enables in bits 6..0, with bit 7 equal to 1.
- R8: A read of the flag register returns the flags in bits 6..0. Bit 7 is the OR of (flag AND enable) over all seven sources.
- R9: `irq_n` is 0 exactly when flag-register bit 7 would read as 1, in the same cycle.
- R10: Reads of any other slot return 0. Writes to any other slot change neither register.
- R11: `rdata` is 0 whenever `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register slot |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, gates `rdata` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| evt | input | 7 | Event pulses, one bit per source |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that `wr_en` and `rd_en` are sampled with a stable `addr` and `wdata` at the clock edge. They also assume that an event lasting one cycle is a single pulse on `evt`, not a level held over many cycles. They make no assumption about how events line up with writes. The bench changes every input at the falling edge and holds it for exactly one rising edge. It sweeps all 256 enable command bytes and all 128 event patterns, each paired with a varying clear mask. It also places an event and a clear on the same flag in the same cycle, and writes to unmapped slots.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  localparam int unsigned NSRC = 7;
  typedef logic [NSRC-1:0] src_vec_t;

  // Enable update for one command byte: bit 7 selects set (1) or clear (0).
  function automatic src_vec_t enable_next(input src_vec_t cur, input logic [7:0] cmd);
    if (cmd[7]) return cur | cmd[NSRC-1:0];
    else        return cur & ~cmd[NSRC-1:0];
  endfunction

  // Flag update: an event takes priority over a clear of the same bit.
  function automatic src_vec_t flag_next(input src_vec_t cur, input src_vec_t ev,
                                         input src_vec_t clr);
    return ev | (cur & ~clr);
  endfunction

  function automatic logic pending(input src_vec_t fl, input src_vec_t en);
    return |(fl & en);
  endfunction
endpackage

// File: rtl/ifr_flag_bank.sv
module ifr_flag_bank
  import ifr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t evt,
  input  src_vec_t clr,
  output src_vec_t flags
);
  src_vec_t flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_next(flag_q, evt, clr);
  end

  assign flags = flag_q;

  // R2 and R4: every pulsed source is set on the next cycle, even when a clear is requested
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

  // R3: a cleared bit with no competing event reads 0 afterwards
  p_clr_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~evt) != '0) |=> ((flags & $past(clr & ~evt)) == '0));

  // R3: bits neither pulsed nor cleared hold their value
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(evt | clr)) == ($past(flags) & ~$past(evt | clr))));
endmodule

// File: rtl/ifr_enable_mask.sv
module ifr_enable_mask
  import ifr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] cmd,
  output src_vec_t   enables
);
  src_vec_t en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= enable_next(en_q, cmd);
  end

  assign enables = en_q;

  p_set_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cmd[7]) |=> ((enables & $past(cmd[NSRC-1:0])) == $past(cmd[NSRC-1:0])));

  p_clr_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !cmd[7]) |=> ((enables & $past(cmd[NSRC-1:0])) == '0));

  p_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((enables & ~$past(wr ? cmd[NSRC-1:0] : '0))
              == ($past(enables) & ~$past(wr ? cmd[NSRC-1:0] : '0))));
endmodule

// File: rtl/ifr_read_mux.sv
module ifr_read_mux
  import ifr_pkg::*;
(
  input  logic       rd_en,
  input  logic       sel_flag,
  input  logic       sel_en,
  input  src_vec_t   flags,
  input  src_vec_t   enables,
  output logic [7:0] rdata,
  output logic       summary
);
  assign summary = pending(flags, enables);

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      if (sel_flag)    rdata = {summary, flags};
      else if (sel_en) rdata = {1'b1, enables};
    end
  end
endmodule

// File: rtl/ifr_irq_unit.sv
module ifr_irq_unit
  import ifr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned FLAG_SLOT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [NSRC-1:0]   evt,
  output logic              irq_n
);
  localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_SLOT);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(FLAG_SLOT + 1);

  // Named internal events
  logic     sel_flag, sel_en, flag_wr, en_wr, summary;
  src_vec_t clr_mask, flags, enables;

  assign sel_flag = (addr == FLAG_A);
  assign sel_en   = (addr == EN_A);
  assign flag_wr  = wr_en && sel_flag;
  assign en_wr    = wr_en && sel_en;
  assign clr_mask = flag_wr ? wdata[NSRC-1:0] : '0;

  ifr_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr_mask), .flags(flags)
  );

  ifr_enable_mask u_enables (
    .clk(clk), .rst_n(rst_n), .wr(en_wr), .cmd(wdata), .enables(enables)
  );

  ifr_read_mux u_rd (
    .rd_en(rd_en), .sel_flag(sel_flag), .sel_en(sel_en),
    .flags(flags), .enables(enables), .rdata(rdata), .summary(summary)
  );

  assign irq_n = ~summary;

  // R9: request tracks the masked flags from the register banks
  p_irq_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == ((flags & enables) == '0));

  // R7: enable reads always carry bit 7 high
  p_en_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_en) |-> rdata[7]);

  // R11: no read strobe, no data
  p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == 8'h00));

  // R10: writes elsewhere leave both registers alone
  p_other_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_flag && !sel_en && evt == '0) |=>
      (flags == $past(flags) && enables == $past(enables)));
endmodule

// File: tb/tb_ifr_irq_unit.sv
module tb_ifr_irq_unit;
  localparam int AW = 4;
  localparam logic [AW-1:0] FA = 4'd13;
  localparam logic [AW-1:0] EA = 4'd14;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [6:0] evt = '0;
  logic irq_n;

  int tests = 0, fails = 0;
  logic [6:0] m_flag = '0, m_en = '0;

  always #2.5 clk = ~clk;

  ifr_irq_unit #(.ADDR_W(AW), .FLAG_SLOT(13)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .evt(evt), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  // one write cycle, with optional event pulse in the same cycle
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic [6:0] e);
    @(negedge clk); addr = a; wdata = d; wr_en = 1; evt = e;
    @(negedge clk); wr_en = 0; evt = '0;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic check_all(input string req);
    logic [7:0] d;
    logic pend;
    pend = |(m_flag & m_en);
    rd(FA, d); check({req, " flag read R8"}, d, {pend, m_flag});
    rd(EA, d); check({req, " enable read R7"}, d, {1'b1, m_en});
    check({req, " irq R9"}, {7'd0, irq_n}, {7'd0, ~pend});
  endtask

  initial begin
    logic [7:0] d;
    #1;
    check("R1 irq during reset", {7'd0, irq_n}, 8'h01);
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("R1 reset state");
    #1 check("R11 idle bus", rdata, 8'h00);

    // R5/R6: sweep all command bytes
    for (int v = 0; v < 256; v++) begin
      logic [7:0] c;
      c = 8'(v * 29 + 7);
      wr(EA, c, '0);
      m_en = c[7] ? (m_en | c[6:0]) : (m_en & ~c[6:0]);
      rd(EA, d);
      check(c[7] ? "R5 set command" : "R6 clear command", d, {1'b1, m_en});
    end

    // R2/R3: every event pattern, then a varying clear mask with bit 7 toggling
    wr(EA, 8'hFF, '0); m_en = 7'h7F;
    for (int p = 0; p < 128; p++) begin
      logic [7:0] c;
      pulse(7'(p));
      m_flag = m_flag | 7'(p);
      rd(FA, d); check("R2 event sets flag", d, {|m_flag, m_flag});
      c = 8'(p * 53 + 11);
      wr(FA, c, '0);
      m_flag = m_flag & ~c[6:0];
      rd(FA, d); check("R3 write-1 clear", d, {|m_flag, m_flag});
    end

    // R8/R9 under partial masks, one source at a time
    wr(FA, 8'h7F, '0); m_flag = '0;
    for (int i = 0; i < 7; i++) begin
      wr(EA, 8'h7F, '0); m_en = '0;
      pulse(7'(1 << i)); m_flag = 7'(1 << i);
      check_all("R8 masked");
      wr(EA, 8'h80 | 8'(1 << i), '0); m_en = 7'(1 << i);
      check_all("R9 enabled");
      wr(EA, 8'h80 | 8'(1 << ((i + 1) % 7)), '0); m_en = m_en | 7'(1 << ((i + 1) % 7));
      wr(FA, 8'(1 << i), '0); m_flag = '0;
      check_all("R9 cleared");
    end

    // R4: event and clear on the same flags in the same cycle
    pulse(7'h7F); m_flag = 7'h7F;
    wr(FA, 8'hFF, 7'h25); m_flag = 7'h25;
    check_all("R4 event beats clear");

    // R10: other slots read 0 and writes there are ignored
    for (int a = 0; a < 16; a++) begin
      if (a == 13 || a == 14) continue;
      wr(AW'(a), 8'hFF, '0);
      wr(AW'(a), 8'h7F, '0);
      rd(AW'(a), d); check("R10 unmapped read", d, 8'h00);
    end
    check_all("R10 registers intact");
    #1 check("R11 idle bus", rdata, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #4_000_000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule